// File: doc/BRIEF.md
# Third-Order One-Bit Noise Shaper

This block turns an oversampled multi-bit PCM stream into a 1-bit stream for a filter-stream DAC. It runs at 128 times the audio sample rate. An upstream interpolator presents one signed sample each time the clock enable is high. A third-order loop then moves the quantization error of the single-bit output out of the audio band and up to high frequencies, where the analog reconstruction stage removes it. One instance serves one channel.

The loop is a chain of three integrators with feedback. The output bit feeds back as plus or minus full scale. Each integrator receives this feedback scaled by 1/8, 1/2 and 1 in turn, and each scale is a plain arithmetic shift. Every integrator saturates at a fixed bound, so a sustained full-scale input cannot drive the loop into runaway. The output bit is the sign decision on the last integrator.

Top module: `noise_shaper_3rd`

## Requirements
- R1: An active-low asynchronous reset clears all three integrators to zero, so `dout` reads 1 while reset is held and directly after it.
- R2: While `en` is low, the integrators and `dout` keep their values, whatever `din` does.
- R3: On each enabled edge, the first integrator adds `din` and subtracts s·2^20. Here s is +1 when `dout` was 1 before the edge and −1 when it was 0.
- R4: On each enabled edge, the second integrator adds the first integrator's value from before the edge and subtracts s·2^22.
- R5: On each enabled edge, the third integrator adds the second integrator's value from before the edge and subtracts s·2^23. When `dout` is 1 and the second integrator is not positive, the third integrator strictly falls. When `dout` is 0 and the second integrator is not negative, it strictly rises.
- R6: `dout` is 1 exactly when the third integrator is zero or positive. The output stream matches bit for bit a model of R3–R5 and R7.
- R7: Each integrator result is clamped to the range −(2^28−1) … +(2^28−1) before it is stored.
- R8: `din` is 24-bit two's complement and is sign-extended. Full scale is 2^23, and the extreme codes 0x7FFFFF and 0x800000 are handled without wrap.
- R9: Starting from reset with zero input, the first enabled edge makes `dout` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock, 128 times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Sample strobe; the loop advances only when high |
| din | input | 24 | Signed PCM sample from the interpolator |
| dout | output | 1 | One-bit shaped output stream |

## Verification
Saturation of an integrator and a flip of the output decision can happen on the same enabled edge. In that cycle the clamped value must feed the sign decision and the feedback for the next step. Full-scale positive and negative inputs are held long enough to pin the integrators at their bounds while the output keeps toggling. Every bit of the resulting stream is compared against an independent model of the update and clamp equations, and an assertion checks that each stored integrator stays inside the bound.

// File: rtl/ns_pkg.sv
package ns_pkg;

    localparam int NS_ORDER = 3;

    typedef enum logic {
        NS_NEG = 1'b0,
        NS_POS = 1'b1
    } ns_sign_e;

    // Right-shift applied to full scale for the feedback of each stage
    function automatic int ns_fb_shift(input int stage);
        case (stage)
            0:       return 3;
            1:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ns_fb_term.sv
module ns_fb_term #(
    parameter int ACC_W   = 32,
    parameter int FS_LOG2 = 23,
    parameter int SHIFT   = 0
) (
    input  ns_pkg::ns_sign_e          q,
    output logic signed [ACC_W-1:0]   term
);
    localparam int MAG_LOG2 = FS_LOG2 - SHIFT;
    localparam logic signed [ACC_W-1:0] MAG = ACC_W'(64'd1 << MAG_LOG2);

    always_comb begin
        if (q == ns_pkg::NS_POS) term = MAG;
        else                     term = -MAG;
    end
endmodule

// File: rtl/ns_sat_stage.sv
module ns_sat_stage #(
    parameter int ACC_W    = 32,
    parameter int SAT_LOG2 = 28
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [ACC_W-1:0] src,
    input  logic signed [ACC_W-1:0] fbt,
    output logic signed [ACC_W-1:0] nxt
);
    localparam int EXT_W = ACC_W + 2;
    localparam logic signed [EXT_W-1:0] HI = EXT_W'((64'd1 << SAT_LOG2) - 64'd1);
    localparam logic signed [EXT_W-1:0] LO = -HI;

    logic signed [EXT_W-1:0] sum;

    always_comb begin
        sum = EXT_W'(acc) + EXT_W'(src) - EXT_W'(fbt);
        if (sum > HI)      nxt = HI[ACC_W-1:0];
        else if (sum < LO) nxt = LO[ACC_W-1:0];
        else               nxt = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/noise_shaper_3rd.sv
module noise_shaper_3rd #(
    parameter int IN_W     = 24,
    parameter int ACC_W    = 32,
    parameter int SAT_LOG2 = 28
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [IN_W-1:0] din,
    output logic                   dout
);
    import ns_pkg::*;

    localparam int ORDER   = NS_ORDER;
    localparam int FS_LOG2 = IN_W - 1;

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] integ;
    } ns_state_t;

    ns_state_t state_d, state_q;
    logic [ORDER-1:0][ACC_W-1:0] integ_q;
    ns_sign_e qbit_q;

    logic signed [ACC_W-1:0] src_d [ORDER];
    logic signed [ACC_W-1:0] fbt_d [ORDER];
    logic signed [ACC_W-1:0] nxt_d [ORDER];

    assign integ_q = state_q.integ;
    assign qbit_q  = integ_q[ORDER-1][ACC_W-1] ? NS_NEG : NS_POS;
    assign dout    = (qbit_q == NS_POS);

    assign src_d[0] = ACC_W'(din);

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k > 0) begin : g_chain
            assign src_d[k] = $signed(integ_q[k-1]);
        end

        ns_fb_term #(
            .ACC_W  (ACC_W),
            .FS_LOG2(FS_LOG2),
            .SHIFT  (ns_fb_shift(k))
        ) i_fb (
            .q   (qbit_q),
            .term(fbt_d[k])
        );

        ns_sat_stage #(
            .ACC_W   (ACC_W),
            .SAT_LOG2(SAT_LOG2)
        ) i_int (
            .acc($signed(integ_q[k])),
            .src(src_d[k]),
            .fbt(fbt_d[k]),
            .nxt(nxt_d[k])
        );
    end

    always_comb begin
        state_d = state_q;
        if (en) begin
            for (int k = 0; k < ORDER; k++) begin
                state_d.integ[k] = nxt_d[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ns_shaper_chk.sv
module ns_shaper_chk #(
    parameter int ACC_W    = 32,
    parameter int SAT_LOG2 = 28,
    parameter int ORDER    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        en,
    input logic                        dout,
    input logic [ORDER-1:0][ACC_W-1:0] integ_q
);
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'((64'd1 << SAT_LOG2) - 64'd1);

    // R1: reset leaves cleared integrators and a high output
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (integ_q == '0 && dout));

    // R2: no movement without a strobe
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(integ_q) && $stable(dout)));

    // R5: feedback pulls the last integrator toward the opposite sign
    p_fb_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dout && $signed(integ_q[1]) <= 0)
        |=> $signed(integ_q[2]) < $signed($past(integ_q[2])));

    p_fb_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dout && $signed(integ_q[1]) >= 0)
        |=> $signed(integ_q[2]) > $signed($past(integ_q[2])));

    // R7: every stored integrator stays within the clamp bound
    for (genvar k = 0; k < ORDER; k++) begin : g_bound
        p_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(integ_q[k]) <= LIM) && ($signed(integ_q[k]) >= -LIM));
    end
endmodule

bind noise_shaper_3rd ns_shaper_chk #(
    .ACC_W   (ACC_W),
    .SAT_LOG2(SAT_LOG2),
    .ORDER   (ORDER)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .dout   (dout),
    .integ_q(integ_q)
);

// File: tb/test_noise_shaper_3rd.sv
module test_noise_shaper_3rd;

    localparam longint FS  = 64'sd1 <<< 23;
    localparam longint LIM = (64'sd1 <<< 28) - 1;

    // {din[23:0], enabled steps[15:0]}
    localparam logic [39:0] VECS [8] = '{
        {24'h000000, 16'd64},
        {24'h030D40, 16'd80},
        {24'hE00000, 16'd80},
        {24'h7FFFFF, 16'd150},
        {24'h800000, 16'd150},
        {24'h000001, 16'd40},
        {24'h100000, 16'd60},
        {24'h000000, 16'd64}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [23:0] din = '0;
    logic        dout;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    longint m1 = 0, m2 = 0, m3 = 0;

    always #2 clk = ~clk;

    noise_shaper_3rd i_noise_shaper_3rd (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .din  (din),
        .dout (dout)
    );

    function automatic longint clampv(input longint v);
        if (v > LIM)  return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic logic model_bit();
        return (m3 >= 0);
    endfunction

    // R3 R4 R5 R7: update equations of the loop
    task automatic model_step(input longint x);
        longint s, n1, n2, n3;
        s  = model_bit() ? FS : -FS;
        n1 = clampv(m1 + x - (s >>> 3));
        n2 = clampv(m2 + m1 - (s >>> 1));
        n3 = clampv(m3 + m2 - s);
        m1 = n1; m2 = n2; m3 = n3;
    endtask

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic step(input logic [23:0] d, input logic e, input string req);
        @(negedge clk);
        din = d;
        en  = e;
        @(posedge clk);
        if (e) model_step(longint'($signed(d)));
        #1;
        check(dout === model_bit(), req, dout, model_bit());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        m1 = 0; m2 = 0; m3 = 0;
        #1;
        check(dout === 1'b1, "R1", dout, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(dout === 1'b1, "R1", dout, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        logic held;

        do_reset();

        // R9: first strobe from reset with silence
        step(24'h000000, 1'b1, "R9");
        check(dout === 1'b0, "R9", dout, 1'b0);

        // R6 R8: table walk compared bit for bit with the model
        for (int v = 0; v < 8; v++) begin
            for (int n = 0; n < int'(VECS[v][15:0]); n++) begin
                step(VECS[v][39:16], 1'b1, (v == 3 || v == 4) ? "R8" : "R6");
            end
        end

        // R2: strobe low while input moves
        held = dout;
        for (int n = 0; n < 6; n++) begin
            step(24'h7FFFFF ^ 24'(n * 24'h123457), 1'b0, "R2");
            check(dout === held, "R2", dout, held);
        end

        // R7: long full-scale run pins integrators, then recovery
        for (int n = 0; n < 300; n++) step(24'h7FFFFF, 1'b1, "R7");
        for (int n = 0; n < 100; n++) step(24'h000000, 1'b1, "R7");
        for (int n = 0; n < 300; n++) step(24'h800000, 1'b1, "R7");

        // R1: reset in mid-stream
        do_reset();
        step(24'h000000, 1'b1, "R9");
        check(dout === 1'b0, "R9", dout, 1'b0);

        // R3 R4 R5: mixed strobe pattern
        for (int n = 0; n < 200; n++) begin
            step(24'(n * 24'h01F3A7), (n % 3) != 1, "R5");
        end

        report();
        $finish;
    end
endmodule